// File: doc/BRIEF.md
# Sector Check-Code Syndrome Decoder

This block takes the two 24-bit Hamming check codes that belong to one 512-byte flash sector, the code stored in the spare area and the code recomputed over the data just received, and decides what happened to the sector. It reports one of three outcomes: the sector is clean, it holds a single flipped data bit that can be repaired, or it cannot be repaired. For a repairable sector it also gives the byte offset (0 to 511) and the bit index (0 to 7) of the bad bit, so that a buffer manager outside the block can invert that one bit. The check-code generator and the data buffer are not part of this block.

Each code carries twelve even-group parities and twelve odd-group parities, one pair for each address bit of the 4096 bits in a sector. The decoder regroups both codes into a common order, XORs them into a 24-bit syndrome, counts its set bits and classifies the count. Two shortcuts sit in front of the count: identical raw codes are clean at once, and an erased sector (stored code all ones, computed code all zeros) is taken as clean.

Control is a two-state machine. In state IDLE the block waits; a start pulse in IDLE latches the syndrome, its population count and the two shortcut flags, and takes the transition IDLE to EVAL. In EVAL the latched values are classified, the result registers are loaded, done is raised for one cycle, and the transition EVAL to IDLE follows unconditionally. Start is not looked at in EVAL.

Top module: `ecc_syn_fix`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, done is 0, status is 2'b00, byte_off is 0 and bit_idx is 0.
- R2: A start sampled in IDLE makes done high for exactly one cycle, beginning after the second rising edge counted from that start; status, byte_off and bit_idx change only together with done and then hold.
- R3: A start sampled while a decode is in progress (the cycle after an accepted start) is ignored: no second done follows and the result is that of the first start.
- R4: When the two 24-bit codes are bitwise equal the status is 2'b00 (clean).
- R5: Code layout: bits 7:0 hold even parities E0..E7, bits 15:8 odd parities O0..O7, bits 19:16 even parities E8..E11, bits 23:20 odd parities O8..O11. Let e and o be the XOR of the two codes on the even and odd parities; a total of 12 set bits in e and o gives status 2'b01 (corrected).
- R6: For status 2'b01, byte_off equals o[11:3] and bit_idx equals o[2:0].
- R7: A total of exactly 1 differing parity bit gives status 2'b10 (uncorrectable, damaged check code).
- R8: A total of exactly 11 differing parity bits gives status 2'b10.
- R9: A stored code of 24'hFFFFFF with a computed code of 24'h000000 gives status 2'b00 (erased sector).
- R10: Any other count (2 to 10, 13 to 24) gives status 2'b10, including an all-ones stored code whose computed code is not zero.
- R11: Whenever status is not 2'b01, byte_off and bit_idx are 0.
- R12: Status only takes the values 2'b00 clean, 2'b01 corrected and 2'b10 uncorrectable; 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a decode of the codes present in this cycle |
| code_stored | input | 24 | Check code read back from the spare area |
| code_calc | input | 24 | Check code computed over the received sector |
| done | output | 1 | One-cycle pulse when a result is loaded |
| status | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| byte_off | output | 9 | Byte offset of the bad bit within the sector |
| bit_idx | output | 3 | Bit index of the bad bit within that byte |

## Verification
On every cycle the assertions watch the timing contract and the output encoding: done is a single-cycle pulse arriving two edges after an accepted start, EVAL always falls back to IDLE regardless of start, results hold between pulses, status never reads 11, the location is zero unless a fix is reported, and both shortcuts (equal codes, erased sector) end clean. Whether the population-count classes, the regrouping of parities and the location bits are right for concrete code pairs can only be shown by the bench's scenarios, which build diffs with chosen counts and chosen error locations (first byte bit 0, last byte bit 7, an interior position) and compare against a model that derives the syndrome straight from the raw code layout.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;

    // parity groups per code: one even and one odd parity per address bit
    localparam int PAR_G  = 12;
    localparam int CODE_W = 2 * PAR_G;
    localparam int BIT_W  = 3;
    localparam int OFF_W  = PAR_G - BIT_W;
    localparam int POPC_W = $clog2(CODE_W + 1);

    typedef enum logic [1:0] {
        ST_CLEAN = 2'b00,
        ST_FIXED = 2'b01,
        ST_BAD   = 2'b10
    } ecc_stat_e;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_EVAL = 1'b1
    } ecc_fsm_e;

    typedef struct packed {
        ecc_stat_e          status;
        logic [OFF_W-1:0]   byte_off;
        logic [BIT_W-1:0]   bit_idx;
    } ecc_result_t;

endpackage

// File: rtl/ecc_code_norm.sv
// Regroups a raw code into three normalized bytes:
//   nb0 = {P64o,P64e,...,P8o,P8e}, nb1 = {P1024o,...,P128e},
//   nb2 = {P4o,P4e,P2o,P2e,P1o,P1e,P2048o,P2048e}
module ecc_code_norm
    import ecc_syn_pkg::*;
(
    input  logic [CODE_W-1:0] raw,
    output logic [CODE_W-1:0] norm
);
    localparam int LOW_G = 8;

    logic [PAR_G-1:0] par_e;
    logic [PAR_G-1:0] par_o;
    logic [7:0]       nb0;
    logic [7:0]       nb1;
    logic [7:0]       nb2;

    // split raw bytes into even and odd parity vectors
    for (genvar i = 0; i < PAR_G; i++) begin : g_split
        if (i < LOW_G) begin : g_low
            assign par_e[i] = raw[i];
            assign par_o[i] = raw[LOW_G + i];
        end else begin : g_high
            assign par_e[i] = raw[2*LOW_G + (i - LOW_G)];
            assign par_o[i] = raw[2*LOW_G + 4 + (i - LOW_G)];
        end
    end

    for (genvar j = 0; j < 4; j++) begin : g_mid
        assign nb0[2*j]     = par_e[3 + j];
        assign nb0[2*j + 1] = par_o[3 + j];
        assign nb1[2*j]     = par_e[7 + j];
        assign nb1[2*j + 1] = par_o[7 + j];
    end

    assign nb2[0] = par_e[PAR_G-1];
    assign nb2[1] = par_o[PAR_G-1];
    for (genvar j = 0; j < 3; j++) begin : g_low3
        assign nb2[2 + 2*j] = par_e[j];
        assign nb2[3 + 2*j] = par_o[j];
    end

    assign norm = {nb2, nb1, nb0};

endmodule

// File: rtl/ecc_syn_map.sv
// XORs two normalized codes, reorders into the syndrome, counts set bits.
module ecc_syn_map
    import ecc_syn_pkg::*;
(
    input  logic [CODE_W-1:0] norm_a,
    input  logic [CODE_W-1:0] norm_b,
    output logic [CODE_W-1:0] syn,
    output logic [POPC_W-1:0] pop
);
    logic [CODE_W-1:0] diff;

    assign diff = norm_a ^ norm_b;

    // syndrome order: low three address pairs, then nb0, nb1, top pair
    assign syn[5:0]   = diff[23:18];
    assign syn[13:6]  = diff[7:0];
    assign syn[21:14] = diff[15:8];
    assign syn[23:22] = diff[17:16];

    always_comb begin
        pop = '0;
        for (int k = 0; k < CODE_W; k++) begin
            pop = pop + POPC_W'(syn[k]);
        end
    end

endmodule

// File: rtl/ecc_syn_class.sv
// Turns a latched syndrome and its count into status and location.
module ecc_syn_class
    import ecc_syn_pkg::*;
#(
    parameter int POP_ONE  = 1,
    parameter int POP_ODD  = 11,
    parameter int POP_CORR = 12
) (
    input  logic [CODE_W-1:0] syn,
    input  logic [POPC_W-1:0] pop,
    input  logic              same,
    input  logic              erased,
    output ecc_result_t       res
);
    logic [OFF_W-1:0] loc_byte;
    logic [BIT_W-1:0] loc_bit;

    // odd-group syndrome bits carry the address of the flipped bit
    for (genvar k = 0; k < OFF_W; k++) begin : g_byte
        assign loc_byte[k] = syn[2*(BIT_W + k) + 1];
    end
    for (genvar k = 0; k < BIT_W; k++) begin : g_bit
        assign loc_bit[k] = syn[2*k + 1];
    end

    always_comb begin
        res = '{status: ST_BAD, byte_off: '0, bit_idx: '0};
        if (same || pop == POPC_W'(0)) begin
            res.status = ST_CLEAN;
        end else if (pop == POPC_W'(POP_ONE) || pop == POPC_W'(POP_ODD)) begin
            res.status = ST_BAD;
        end else if (pop == POPC_W'(POP_CORR)) begin
            res.status   = ST_FIXED;
            res.byte_off = loc_byte;
            res.bit_idx  = loc_bit;
        end else if (erased) begin
            res.status = ST_CLEAN;
        end
    end

endmodule

// File: rtl/ecc_syn_fix.sv
module ecc_syn_fix
    import ecc_syn_pkg::*;
#(
    parameter int POP_ONE  = 1,
    parameter int POP_ODD  = 11,
    parameter int POP_CORR = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [23:0]       code_stored,
    input  logic [23:0]       code_calc,
    output logic              done,
    output logic [1:0]        status,
    output logic [8:0]        byte_off,
    output logic [2:0]        bit_idx
);
    ecc_fsm_e          state, state_nx;
    logic [CODE_W-1:0] norm_st, norm_ca;
    logic [CODE_W-1:0] syn_d, syn_q;
    logic [POPC_W-1:0] pop_d, pop_q;
    logic              same_q, erased_q;
    ecc_result_t       res_d, res_q;
    logic              done_q;
    logic              accept;

    ecc_code_norm u_norm_st (.raw(code_stored), .norm(norm_st));
    ecc_code_norm u_norm_ca (.raw(code_calc),   .norm(norm_ca));

    ecc_syn_map u_map (
        .norm_a (norm_st),
        .norm_b (norm_ca),
        .syn    (syn_d),
        .pop    (pop_d)
    );

    ecc_syn_class #(
        .POP_ONE  (POP_ONE),
        .POP_ODD  (POP_ODD),
        .POP_CORR (POP_CORR)
    ) u_class (
        .syn    (syn_q),
        .pop    (pop_q),
        .same   (same_q),
        .erased (erased_q),
        .res    (res_d)
    );

    assign accept = (state == S_IDLE) && start;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = S_EVAL;
            S_EVAL: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // stage 1: latch syndrome and shortcut flags on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syn_q    <= '0;
            pop_q    <= '0;
            same_q   <= 1'b0;
            erased_q <= 1'b0;
        end else if (accept) begin
            syn_q    <= syn_d;
            pop_q    <= pop_d;
            same_q   <= (code_stored == code_calc);
            erased_q <= (&code_stored) && (code_calc == '0);
        end
    end

    // stage 2: result registers and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q  <= '{status: ST_CLEAN, byte_off: '0, bit_idx: '0};
            done_q <= 1'b0;
        end else begin
            done_q <= (state == S_EVAL);
            if (state == S_EVAL) res_q <= res_d;
        end
    end

    assign done     = done_q;
    assign status   = res_q.status;
    assign byte_off = res_q.byte_off;
    assign bit_idx  = res_q.bit_idx;

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |-> ##2 done);
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(status) && $stable(byte_off) && $stable(bit_idx)));
    p_busy_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EVAL) |=> (state == S_IDLE && !done_q == 1'b0));
    p_fast_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EVAL && same_q) |=> (status == 2'b00));
    p_erased_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EVAL && erased_q) |=> (status == 2'b00));
    p_loc_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b01) |-> (byte_off == '0 && bit_idx == '0));
    p_status_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);

endmodule

// File: tb/ecc_syn_fix_bench.sv
module ecc_syn_fix_bench;
    localparam time CLK_T = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] code_stored = '0;
    logic [23:0] code_calc = '0;
    logic        done;
    logic [1:0]  status;
    logic [8:0]  byte_off;
    logic [2:0]  bit_idx;

    int total = 0;
    int bad = 0;

    ecc_syn_fix u_ecc_syn_fix (
        .clk, .rst_n, .start, .code_stored, .code_calc,
        .done, .status, .byte_off, .bit_idx
    );

    always #(CLK_T/2) clk = ~clk;

    // raw code from even/odd parity vectors (layout from R5)
    function automatic logic [23:0] raw_of(logic [11:0] e, logic [11:0] o);
        return {o[11:8], e[11:8], o[7:0], e[7:0]};
    endfunction

    // behavioural reference: {status, byte_off, bit_idx}
    function automatic logic [13:0] ref_eval(logic [23:0] st, logic [23:0] ca);
        logic [23:0] d;
        logic [11:0] e, o;
        int cnt;
        d = st ^ ca;
        e = {d[19:16], d[7:0]};
        o = {d[23:20], d[15:8]};
        cnt = $countones(e) + $countones(o);
        if (st == ca || cnt == 0) return {2'b00, 12'd0};
        if (cnt == 1 || cnt == 11) return {2'b10, 12'd0};
        if (cnt == 12) return {2'b01, o[11:3], o[2:0]};
        if (st == 24'hFFFFFF && ca == 24'h0) return {2'b00, 12'd0};
        return {2'b10, 12'd0};
    endfunction

    // cycle model: queue of pending results, countdown in integers
    logic [13:0] m_res = '0;
    logic        m_done = 1'b0;
    int          m_busy = 0;
    logic [13:0] m_q[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_res = '0; m_done = 1'b0; m_busy = 0; m_q.delete();
        end else begin
            m_done = 1'b0;
            if (m_busy == 1) begin
                m_res  = m_q.pop_front();
                m_done = 1'b1;
                m_busy = 0;
            end else if (start) begin
                m_q.push_back(ref_eval(code_stored, code_calc));
                m_busy = 1;
            end
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 cycle model", {done, status, byte_off, bit_idx},
                  {m_done, m_res});
            check("R12 legal status", 32'(status != 2'b11), 32'd1);
        end
    end

    // one decode with explicit expectations, sampled between edges
    task automatic run(string tag, logic [23:0] st, logic [23:0] ca,
                       logic [1:0] es, logic [8:0] eo, logic [2:0] eb);
        @(negedge clk);
        start = 1'b1; code_stored = st; code_calc = ca;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R2 no early done"}, 32'(done), 32'd0);
        @(negedge clk);
        check({tag, " R2 done"}, 32'(done), 32'd1);
        check({tag, " status"}, 32'(status), 32'(es));
        check({tag, " location"}, {byte_off, bit_idx}, {eo, eb});
        @(negedge clk);
        check({tag, " R2 pulse ends"}, 32'(done), 32'd0);
        check({tag, " R2 hold"}, {status, byte_off, bit_idx}, {es, eo, eb});
    endtask

    initial begin
        #(CLK_T * 100000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [11:0] loc;
        #(CLK_T * 3);
        check("R1 reset done", 32'(done), 32'd0);
        check("R1 reset outputs", {status, byte_off, bit_idx}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {done, status, byte_off, bit_idx}, 32'd0);

        run("R4 equal", 24'h123456, 24'h123456, 2'b00, 9'd0, 3'd0);

        loc = {9'h1A5, 3'd6};
        run("R5 R6 interior", 24'h5A3C96 ^ raw_of(~loc, loc), 24'h5A3C96,
            2'b01, 9'h1A5, 3'd6);
        loc = 12'h000;
        run("R6 first bit", 24'h00F00F ^ raw_of(~loc, loc), 24'h00F00F,
            2'b01, 9'd0, 3'd0);
        loc = 12'hFFF;
        run("R6 last bit", 24'hABCDEF ^ raw_of(~loc, loc), 24'hABCDEF,
            2'b01, 9'd511, 3'd7);

        run("R7 one bit", 24'h000400 ^ 24'h3C3C3C, 24'h3C3C3C, 2'b10, 9'd0, 3'd0);
        run("R8 eleven", 24'h0007FF ^ 24'h777000, 24'h777000, 2'b10, 9'd0, 3'd0);
        run("R9 erased", 24'hFFFFFF, 24'h000000, 2'b00, 9'd0, 3'd0);
        run("R10 erased dirty", 24'hFFFFFF, 24'h000001, 2'b10, 9'd0, 3'd0);
        run("R10 two bits", 24'h010001 ^ 24'h55AA55, 24'h55AA55, 2'b10, 9'd0, 3'd0);
        run("R10 thirteen", 24'h001FFF, 24'h000000, 2'b10, 9'd0, 3'd0);

        // R11: a fix followed by an uncorrectable clears the location
        loc = {9'h0F3, 3'd2};
        run("R11 fix", raw_of(~loc, loc), 24'h0, 2'b01, 9'h0F3, 3'd2);
        run("R11 clear", 24'h000003, 24'h0, 2'b10, 9'd0, 3'd0);

        // R3: start held into the busy cycle with codes that would fail
        @(negedge clk);
        start = 1'b1; code_stored = 24'h0A0B0C; code_calc = 24'h0A0B0C;
        @(negedge clk);
        code_stored = 24'h0A0B0D;
        @(negedge clk);
        start = 1'b0;
        check("R3 first done", 32'(done), 32'd1);
        check("R3 first result", 32'(status), 32'd0);
        @(negedge clk);
        check("R3 no second done", 32'(done), 32'd0);
        @(negedge clk);
        check("R3 still none", 32'(done), 32'd0);
        check("R3 result kept", 32'(status), 32'd0);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule